// File: doc/BRIEF.md
# Multi-mode ADC channel scan sequencer

This block schedules conversions for an eight-input multiplexed ADC front end. A small write-only register port holds three words: a control word, a start-rate divisor and a packed per-channel gain word. Writing the control word with its run bit set arms a rate generator. The generator fires start events every `divisor` clock cycles. A divisor of zero gives exactly one start and then stops.

Each start produces a conversion request that carries a channel number, a gain code and a differential flag. The mode field of the control word decides how the channel and gain are chosen. In fixed-channel mode one channel is converted each time. In basic sequence mode the channel cycles from 0 up to a programmed last channel, using the control-word gain. Advanced sequence mode walks the same range but reads each channel's gain from its own nybble of the gain word. A fourth mode code changes the fields of a running sequence without disturbing its position or timing.

With the scan bit set and a last channel above zero, each start instead releases a burst of back-to-back requests covering channels 0 up to the last channel. A start that arrives while a burst is still running is dropped and flagged. A control write can also forward its low half-word to the converter configuration.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, `req_valid`, `overrun` and `cfg_load` are 0, and no request appears until the control word is written with its run bit (bit 16) set.
- R2: The register port selects the control word at address 0 and the divisor at address 1. A control write in clock edge P with bit 16 = 1 and a mode field (bits 8:7) other than 01 makes the first request visible after edge P+1. With divisor D of at least 1, further requests follow every D cycles.
- R3: With divisor 0, such a run write produces exactly one start and then the sequencer goes idle.
- R4: Mode 00 (fixed channel) requests the channel in control bits 2:0 every time, with the gain code in control bits 6:4.
- R5: Mode 11 (basic sequence) requests channels 0, 1, … up to the last channel (bits 2:0) on successive starts, then wraps to 0. The gain is taken from control bits 6:4.
- R6: Mode 10 (advanced sequence) walks the channels as in R5, but the gain for channel k is bits 4k+2:4k of the gain word at address 2. Control bits 6:4 and bit 4k+3 have no effect on it.
- R7: A control write with mode 01 replaces the last channel, gain and single-ended bit, and switches the mode to basic sequence. It keeps the sequence pointer, the rate counter, the run state and the scan setting, and its bit 16 is ignored.
- R8: With scan (bit 18) set and a last channel above 0, each start emits last+1 requests on consecutive cycles, for channels 0 through last in order.
- R9: A start that occurs while a burst is still being emitted produces no request. It raises `overrun` for one cycle, and the following bursts keep their normal order.
- R10: `req_diff` is the inverse of control bit 3: 1 selects a single-ended measurement, so `req_diff` = 0.
- R11: A control write with bit 17 set pulses `cfg_load` for one cycle right after the write edge, with `cfg_word` equal to bits 15:0 of that write. A control write without bit 17 leaves both `cfg_load` low and `cfg_word` unchanged.
- R12: A control write with bit 16 = 0 and a mode other than 01 stops the sequencer, clears the rate counter, the burst and the sequence pointer, and no further request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the base clock of the start-rate divider |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 divisor, 2 gain word |
| wr_data | input | 32 | Register write data |
| req_valid | output | 1 | Conversion request strobe, one cycle per conversion |
| req_ch | output | $clog2(NUM_CH) | Channel of the request |
| req_gain | output | GAIN_W | Gain code of the request |
| req_diff | output | 1 | 1 for a differential measurement |
| overrun | output | 1 | Pulses when a start is dropped during a burst |
| cfg_load | output | 1 | Pulses when a configuration half-word is forwarded |
| cfg_word | output | 16 | Forwarded configuration half-word |

## Verification
The bench builds the block with eight channels, a three-bit gain code and an eight-bit divisor. With eight channels, the advanced mode's gain word fills all 32 bits, so every nybble position is exercised. The small divisor values used (0, 1, 2, 3, 4 and 6) put one-shot runs, back-to-back starts, bursts that fit inside the start period, and bursts overrun by the next start all within a few dozen cycles. Every request is then checked at an exact cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Sequencing mode codes held in the control word
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_UPDATE = 2'b01,
    MODE_ADV    = 2'b10,
    MODE_BASIC  = 2'b11
  } seq_mode_e;

  // Register select codes
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_GAIN = 2'd2;

  // Fixed control-word bit positions above the forwarded half-word
  localparam int CFG_W    = 16;
  localparam int GO_BIT   = 16;
  localparam int CFG_BIT  = 17;
  localparam int SCAN_BIT = 18;

  // Width of one per-channel slot in the gain word
  localparam int NYB_W = 4;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 16,
  parameter int GAIN_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [31:0]               wr_data,
  output logic                      go_pulse,
  output logic                      stop_pulse,
  output seq_mode_e                 mode,
  output logic [$clog2(NUM_CH)-1:0] last_ch,
  output logic                      com,
  output logic [GAIN_W-1:0]         gain,
  output logic                      scan,
  output logic [DIV_W-1:0]          div,
  output logic [NYB_W*NUM_CH-1:0]   gain_word,
  output logic                      cfg_load,
  output logic [CFG_W-1:0]          cfg_word
);

  localparam int CH_W     = $clog2(NUM_CH);
  localparam int GW_W     = NYB_W * NUM_CH;
  localparam int COM_POS  = CH_W;
  localparam int GAIN_LSB = CH_W + 1;
  localparam int MODE_LSB = GAIN_LSB + GAIN_W;

  logic      ctrl_wr;
  logic      upd_pulse;
  seq_mode_e wr_mode;

  assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_mode    = seq_mode_e'(wr_data[MODE_LSB +: 2]);
  assign upd_pulse  = ctrl_wr && (wr_mode == MODE_UPDATE);
  assign go_pulse   = ctrl_wr && !upd_pulse && wr_data[GO_BIT];
  assign stop_pulse = ctrl_wr && !upd_pulse && !wr_data[GO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_SINGLE;
      last_ch   <= '0;
      com       <= 1'b0;
      gain      <= '0;
      scan      <= 1'b0;
      div       <= '0;
      gain_word <= '0;
      cfg_load  <= 1'b0;
      cfg_word  <= '0;
    end else begin
      cfg_load <= ctrl_wr && wr_data[CFG_BIT];
      if (ctrl_wr && wr_data[CFG_BIT]) cfg_word <= wr_data[CFG_W-1:0];
      if (ctrl_wr) begin
        last_ch <= wr_data[CH_W-1:0];
        com     <= wr_data[COM_POS];
        gain    <= wr_data[GAIN_LSB +: GAIN_W];
        if (upd_pulse) begin
          mode <= MODE_BASIC;
        end else begin
          mode <= wr_mode;
          scan <= wr_data[SCAN_BIT];
        end
      end
      if (wr_en && (wr_addr == ADDR_DIV))  div       <= wr_data[DIV_W-1:0];
      if (wr_en && (wr_addr == ADDR_GAIN)) gain_word <= wr_data[GW_W-1:0];
    end
  end

  // R11: the forwarded half-word is the one written with the config bit
  p_cfg_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[CFG_BIT]) |=> (cfg_load && (cfg_word == $past(wr_data[CFG_W-1:0]))));

  // R7: an update write leaves the scan setting alone
  p_upd_keeps_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> $stable(scan));

endmodule

// File: rtl/adc_seq_rate.sv
module adc_seq_rate #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_pulse,
  input  logic             stop_pulse,
  input  logic [DIV_W-1:0] div,
  output logic             start_evt
);

  logic             running;
  logic [DIV_W-1:0] cnt;

  // Divider step: wraps to zero once the period is reached
  function automatic logic [DIV_W-1:0] next_count(input logic [DIV_W-1:0] c,
                                                  input logic [DIV_W-1:0] d);
    if (d == '0) return '0;
    return (c >= d - DIV_W'(1)) ? '0 : c + DIV_W'(1);
  endfunction

  assign start_evt = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (stop_pulse) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (go_pulse) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (start_evt && (div == '0)) running <= 1'b0;
      else                          cnt     <= next_count(cnt, div);
    end
  end

  // R3: a zero divisor gives one start and then idles
  p_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && (div == '0) && !go_pulse) |=> !running);

  // R2: with a period above one, starts are never back to back
  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && (div > DIV_W'(1)) && !go_pulse) |=> !start_evt);

  // R12: a stop write halts the divider
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> (!running && (cnt == '0)));

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int GAIN_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      start_evt,
  input  seq_mode_e                 mode,
  input  logic [$clog2(NUM_CH)-1:0] last_ch,
  input  logic                      com,
  input  logic [GAIN_W-1:0]         gain,
  input  logic                      scan,
  input  logic [NYB_W*NUM_CH-1:0]   gain_word,
  output logic                      req_valid,
  output logic [$clog2(NUM_CH)-1:0] req_ch,
  output logic [GAIN_W-1:0]         req_gain,
  output logic                      req_diff,
  output logic                      overrun
);

  localparam int CH_W = $clog2(NUM_CH);
  localparam int GW_W = NYB_W * NUM_CH;

  logic            busy, busy_n;
  logic [CH_W-1:0] bptr, bptr_n;
  logic [CH_W-1:0] ptr, ptr_n;
  logic            emit_v;
  logic [CH_W-1:0] emit_ch;
  logic [CH_W-1:0] seq_now;
  logic            ovr_n;
  logic            burst_mode;

  // Pointer left beyond a shortened range restarts at channel 0
  function automatic logic [CH_W-1:0] clip_ptr(input logic [CH_W-1:0] p,
                                               input logic [CH_W-1:0] last);
    return (p > last) ? '0 : p;
  endfunction

  function automatic logic [CH_W-1:0] step_ch(input logic [CH_W-1:0] c,
                                              input logic [CH_W-1:0] last);
    return (c >= last) ? '0 : c + CH_W'(1);
  endfunction

  // Advanced mode reads the low GAIN_W bits of the channel's nybble
  function automatic logic [GAIN_W-1:0] pick_gain(input seq_mode_e m,
                                                  input logic [CH_W-1:0] c,
                                                  input logic [GAIN_W-1:0] g,
                                                  input logic [GW_W-1:0] w);
    if (m == MODE_ADV) return w[c*NYB_W +: GAIN_W];
    return g;
  endfunction

  assign burst_mode = scan && (last_ch != '0);
  assign seq_now    = clip_ptr(ptr, last_ch);

  always_comb begin
    emit_v  = 1'b0;
    emit_ch = '0;
    busy_n  = busy;
    bptr_n  = bptr;
    ptr_n   = ptr;
    ovr_n   = 1'b0;
    if (clear) begin
      busy_n = 1'b0;
      bptr_n = '0;
      ptr_n  = '0;
    end else begin
      if (busy) begin
        emit_v  = 1'b1;
        emit_ch = bptr;
        if (bptr >= last_ch) begin
          busy_n = 1'b0;
          bptr_n = '0;
        end else begin
          bptr_n = bptr + CH_W'(1);
        end
      end
      if (start_evt) begin
        if (busy) begin
          ovr_n = 1'b1;
        end else if (burst_mode) begin
          emit_v  = 1'b1;
          emit_ch = '0;
          busy_n  = 1'b1;
          bptr_n  = CH_W'(1);
        end else begin
          emit_v = 1'b1;
          if (mode == MODE_SINGLE) begin
            emit_ch = last_ch;
          end else begin
            emit_ch = seq_now;
            ptr_n   = step_ch(seq_now, last_ch);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bptr      <= '0;
      ptr       <= '0;
      req_valid <= 1'b0;
      req_ch    <= '0;
      req_gain  <= '0;
      req_diff  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      busy      <= busy_n;
      bptr      <= bptr_n;
      ptr       <= ptr_n;
      req_valid <= emit_v;
      overrun   <= ovr_n;
      if (emit_v) begin
        req_ch   <= emit_ch;
        req_gain <= pick_gain(mode, emit_ch, gain, gain_word);
        req_diff <= ~com;
      end
    end
  end

  // R8: an open burst keeps emitting on every cycle
  p_burst_cont_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear) |=> req_valid);

  // R9: a start during a burst is flagged
  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && busy && !clear) |=> overrun);

  // R9: the flag only follows a busy cycle
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy));

  // R12: clearing ends the burst and suppresses the request
  p_clear_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!req_valid && !busy && (ptr == '0)));

  // R4: a lone start in fixed mode converts the programmed channel
  p_single_ch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !busy && !clear && !burst_mode && (mode == MODE_SINGLE))
      |=> (req_valid && (req_ch == $past(last_ch))));

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 16,
  parameter int GAIN_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [31:0]               wr_data,
  output logic                      req_valid,
  output logic [$clog2(NUM_CH)-1:0] req_ch,
  output logic [GAIN_W-1:0]         req_gain,
  output logic                      req_diff,
  output logic                      overrun,
  output logic                      cfg_load,
  output logic [15:0]               cfg_word
);

  localparam int CH_W = $clog2(NUM_CH);
  localparam int GW_W = NYB_W * NUM_CH;

  logic              go_pulse;
  logic              stop_pulse;
  logic              seq_clear;
  logic              start_evt;
  seq_mode_e         mode;
  logic [CH_W-1:0]   last_ch;
  logic              com;
  logic [GAIN_W-1:0] gain;
  logic              scan;
  logic [DIV_W-1:0]  div;
  logic [GW_W-1:0]   gain_word;

  assign seq_clear = go_pulse | stop_pulse;

  adc_seq_regs #(.NUM_CH(NUM_CH), .DIV_W(DIV_W), .GAIN_W(GAIN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .go_pulse   (go_pulse),
    .stop_pulse (stop_pulse),
    .mode       (mode),
    .last_ch    (last_ch),
    .com        (com),
    .gain       (gain),
    .scan       (scan),
    .div        (div),
    .gain_word  (gain_word),
    .cfg_load   (cfg_load),
    .cfg_word   (cfg_word)
  );

  adc_seq_rate #(.DIV_W(DIV_W)) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_pulse   (go_pulse),
    .stop_pulse (stop_pulse),
    .div        (div),
    .start_evt  (start_evt)
  );

  adc_seq_chan #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (seq_clear),
    .start_evt  (start_evt),
    .mode       (mode),
    .last_ch    (last_ch),
    .com        (com),
    .gain       (gain),
    .scan       (scan),
    .gain_word  (gain_word),
    .req_valid  (req_valid),
    .req_ch     (req_ch),
    .req_gain   (req_gain),
    .req_diff   (req_diff),
    .overrun    (overrun)
  );

endmodule

// File: tb/tb_adc_scan_sequencer.sv
module tb_adc_scan_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int DIV_W  = 8;
  localparam int GAIN_W = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_GAIN = 2'd2;

  localparam logic [1:0] M_FIX = 2'b00;
  localparam logic [1:0] M_UPD = 2'b01;
  localparam logic [1:0] M_ADV = 2'b10;
  localparam logic [1:0] M_BAS = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        req_valid;
  logic [2:0]  req_ch;
  logic [2:0]  req_gain;
  logic        req_diff;
  logic        overrun;
  logic        cfg_load;
  logic [15:0] cfg_word;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_scan_sequencer #(.NUM_CH(NUM_CH), .DIV_W(DIV_W), .GAIN_W(GAIN_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ch(req_ch), .req_gain(req_gain), .req_diff(req_diff),
    .overrun(overrun), .cfg_load(cfg_load), .cfg_word(cfg_word)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", rq, what, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit go, input bit scan, input logic [1:0] mode,
                                          input int gn, input bit com, input int last);
    logic [31:0] d;
    d = '0;
    d[2:0]  = 3'(last);
    d[3]    = com;
    d[6:4]  = 3'(gn);
    d[8:7]  = mode;
    d[16]   = go;
    d[18]   = scan;
    return d;
  endfunction

  // Called at a falling edge; the write is taken at the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic expect_req(input bit ev, input int ch, input int gn, input bit df,
                            input string tv, input string tc);
    chk(req_valid == ev, tv, "req_valid", int'(req_valid), int'(ev));
    if (ev && req_valid) begin
      chk(int'(req_ch) == ch, tc, "req_ch", int'(req_ch), ch);
      chk(int'(req_gain) == gn, tc, "req_gain", int'(req_gain), gn);
      chk(req_diff == df, "R10", "req_diff", int'(req_diff), int'(df));
    end
  endtask

  task automatic expect_idle(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req_valid == 1'b0, rq, "req_valid while idle", int'(req_valid), 0);
    end
  endtask

  task automatic stop_run(input string rq);
    wr(A_CTRL, mk_ctrl(1'b0, 1'b0, M_FIX, 0, 1'b0, 0));
    expect_idle(6, rq);
  endtask

  task automatic t_reset();
    chk(req_valid == 1'b0, "R1", "req_valid after reset", int'(req_valid), 0);
    chk(overrun == 1'b0, "R1", "overrun after reset", int'(overrun), 0);
    chk(cfg_load == 1'b0, "R1", "cfg_load after reset", int'(cfg_load), 0);
    expect_idle(5, "R1");
  endtask

  task automatic t_fixed();
    wr(A_DIV, 32'd3);
    wr(A_CTRL, mk_ctrl(1'b1, 1'b0, M_FIX, 2, 1'b1, 5));
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      expect_req(((i - 1) % 3) == 0, 5, 2, 1'b0, "R2", "R4");
    end
    stop_run("R12");
  endtask

  task automatic t_oneshot();
    wr(A_DIV, 32'd0);
    for (int rep = 0; rep < 2; rep++) begin
      wr(A_CTRL, mk_ctrl(1'b1, 1'b0, M_BAS, 4, 1'b0, 2));
      for (int i = 1; i <= 8; i++) begin
        @(negedge clk);
        expect_req(i == 1, 0, 4, 1'b1, "R3", "R3");
      end
    end
    stop_run("R12");
  endtask

  task automatic t_basic();
    wr(A_DIV, 32'd1);
    wr(A_CTRL, mk_ctrl(1'b1, 1'b0, M_BAS, 1, 1'b1, 2));
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      expect_req(1'b1, (i - 1) % 3, 1, 1'b0, "R5", "R5");
    end
    stop_run("R12");
    // restart after a stop begins again at channel 0
    wr(A_CTRL, mk_ctrl(1'b1, 1'b0, M_BAS, 1, 1'b1, 2));
    @(negedge clk);
    expect_req(1'b1, 0, 1, 1'b0, "R12", "R12");
    stop_run("R12");
  endtask

  task automatic t_adv();
    logic [31:0] gw;
    gw = '0;
    for (int k = 0; k < 8; k++) gw[4*k +: 4] = {1'b1, 3'(k ^ 5)};
    wr(A_GAIN, gw);
    wr(A_DIV, 32'd1);
    wr(A_CTRL, mk_ctrl(1'b1, 1'b0, M_ADV, 7, 1'b1, 7));
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      expect_req(1'b1, (i - 1) % 8, ((i - 1) % 8) ^ 5, 1'b0, "R6", "R6");
    end
    stop_run("R12");
  endtask

  task automatic t_update();
    wr(A_DIV, 32'd4);
    wr(A_CTRL, mk_ctrl(1'b1, 1'b0, M_BAS, 1, 1'b1, 3));
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      expect_req(i == 1 || i == 5 || i == 9, (i - 1) / 4, 1, 1'b0, "R5", "R5");
    end
    // update with run bit clear: must not stop or rewind
    wr(A_CTRL, mk_ctrl(1'b0, 1'b0, M_UPD, 6, 1'b0, 3));
    for (int j = 11; j <= 17; j++) begin
      @(negedge clk);
      expect_req(j == 13 || j == 17, (j == 13) ? 3 : 0, 6, 1'b1, "R7", "R7");
    end
    stop_run("R12");
  endtask

  task automatic t_burst();
    wr(A_DIV, 32'd6);
    wr(A_CTRL, mk_ctrl(1'b1, 1'b1, M_FIX, 3, 1'b1, 3));
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      expect_req(((i - 1) % 6) < 4, (i - 1) % 6, 3, 1'b0, "R8", "R8");
      chk(overrun == 1'b0, "R9", "overrun without collision", int'(overrun), 0);
    end
    stop_run("R12");
  endtask

  task automatic t_overrun();
    wr(A_DIV, 32'd2);
    wr(A_CTRL, mk_ctrl(1'b1, 1'b1, M_FIX, 5, 1'b0, 3));
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      expect_req(1'b1, (i - 1) % 4, 5, 1'b1, "R9", "R9");
      chk(overrun == (((i - 1) % 4) == 2), "R9", "overrun", int'(overrun),
          int'(((i - 1) % 4) == 2));
    end
    stop_run("R12");
  endtask

  task automatic t_cfg();
    wr(A_CTRL, 32'h0002_5A3C);
    chk(cfg_load == 1'b1, "R11", "cfg_load pulse", int'(cfg_load), 1);
    chk(cfg_word == 16'h5A3C, "R11", "cfg_word", int'(cfg_word), 'h5A3C);
    @(negedge clk);
    chk(cfg_load == 1'b0, "R11", "cfg_load one cycle", int'(cfg_load), 0);
    wr(A_CTRL, 32'h0000_1234);
    chk(cfg_load == 1'b0, "R11", "cfg_load without bit 17", int'(cfg_load), 0);
    chk(cfg_word == 16'h5A3C, "R11", "cfg_word held", int'(cfg_word), 'h5A3C);
    expect_idle(3, "R12");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_oneshot();
    t_basic();
    t_adv();
    t_update();
    t_burst();
    t_overrun();
    t_cfg();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule